// File: doc/BRIEF.md
# Init Handshake and SPI Ownership Arbiter

This block holds the few words that a host and an embedded controller share while two link retimers are brought up. The host puts a start request in the control word, together with one 2-bit error-correction request per link. The embedded controller reads those requests, configures the retimers over a single SPI master, writes the firmware version and one mode/status word per retimer, and finally raises a done flag. The block answers host reads of all of these words through a small read port with one cycle of latency.

The same SPI master pins serve both parties. While done is clear, the embedded controller's SPI port drives the pins. Once done is set, ownership moves to the host port, but only at a moment when the embedded side has every chip select released. Ownership then stays with the host until reset. The handover does not depend on whether the configuration succeeded. The block also derives three registered status flags from the shared words: firmware missing, configuration good, and a flag saying that at least one retimer runs in a mode where error correction applies.

Top module: `init_handshake_arbiter`

## Requirements
- R1: After a synchronous reset, every shared word reads as 0. The embedded side owns the SPI master. All SPI chip selects are high, with sclk and mosi low. The firmware-missing flag is 1, and the configuration-good and correction-applies flags are 0.
- R2: A host write to address 0x1000 loads only bit 1 (start) and bits 23:8 (correction requests). A host read of 0x1000 returns done in bit 0, start in bit 1 and the requests in bits 23:8, with every other bit 0. Start and the requests go to the embedded side on emb_start and emb_fec_req, and embedded-side writes never change them.
- R3: Bits 23:8 hold eight 2-bit requests. Slot k (0..7) sits at bits 9+2k:8+2k, and the same slot k appears at bits 2k+1:2k of emb_fec_req. Slots 0-3 are retimer A links 0-3 and slots 4-7 are retimer B links 0-3. The codes are 0 none, 1 Fire Code, 2 Reed-Solomon, and every 2-bit value is stored as written.
- R4: Host writes to the version word (0x1004) or to either mode word (0x1020 for retimer A, 0x1024 for retimer B) have no effect.
- R5: An embedded write to 0x1000 with bit 0 set sets done. Done then stays set until reset, whatever either side writes afterwards.
- R6: Embedded writes load the version word and the two mode words in full. The host reads them back, with rdata valid one cycle after the read strobe, and any unmapped address reads 0.
- R7: While the embedded side is owner, the SPI pins copy the embedded port one cycle later. Host SPI inputs are ignored, host_miso is 0 and emb_miso follows spi_miso.
- R8: Ownership moves to the host only once done is set and all embedded chip selects are high. Ownership is not granted while an embedded transfer is active, and it is granted even when a mode word reports a failing status code.
- R9: Once the host owns the SPI master, the pins copy the host port one cycle later. Embedded SPI inputs are ignored, emb_miso is 0, host_miso follows spi_miso, and ownership never returns to the embedded side until reset.
- R10: fw_absent is 1 exactly when the version word is 0 (major in bits 31:28, minor 27:24, patch 23:20), one cycle after that word changes.
- R11: cfg_ok is 1 when done is set and the status code in bits 15:8 of both mode words is 0.
- R12: fec_active is 1 when the mode ID in bits 7:0 of either mode word is not 0 (reset) and not 1 (four 10G links). IDs 2 to 5 are the 25G layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_rvalid | output | 1 | host_rdata valid |
| emb_wr_en | input | 1 | Embedded write strobe |
| emb_addr | input | ADDR_W | Embedded word address |
| emb_wdata | input | 32 | Embedded write data |
| emb_start | output | 1 | Start request seen by the embedded side |
| emb_fec_req | output | 16 | Packed correction requests, slot k at bits 2k+1:2k |
| emb_sclk | input | 1 | Embedded SPI clock |
| emb_mosi | input | 1 | Embedded SPI data out |
| emb_cs_n | input | NUM_CS | Embedded SPI chip selects, active low |
| emb_miso | output | 1 | SPI data in, returned to embedded side |
| host_sclk | input | 1 | Host SPI clock |
| host_mosi | input | 1 | Host SPI data out |
| host_cs_n | input | NUM_CS | Host SPI chip selects, active low |
| host_miso | output | 1 | SPI data in, returned to host side |
| spi_sclk | output | 1 | SPI clock pin |
| spi_mosi | output | 1 | SPI data out pin |
| spi_cs_n | output | NUM_CS | SPI chip select pins |
| spi_miso | input | 1 | SPI data in pin |
| host_owns | output | 1 | 1 once the host owns the SPI master |
| fw_absent | output | 1 | Version word is zero |
| cfg_ok | output | 1 | Done set and both status codes OK |
| fec_active | output | 1 | A retimer runs in a mode where correction applies |

## Verification
The hardest case to reach from the ports is done arriving while the embedded side is in the middle of a transfer. The bench holds an embedded chip select low across the done write, checks that ownership is still withheld several cycles later, and only then releases the select. That same pass loads a failing status code before done, so the handover is also seen to go ahead when configuration is bad. The 2-bit request slots and all 64 pairs of 3-bit mode IDs are swept exhaustively.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int WORD_W       = 32;
  localparam int NUM_RT       = 2;
  localparam int LINKS_PER_RT = 4;
  localparam int FEC_W        = 2;
  localparam int FEC_LSB      = 8;
  localparam int FEC_BITS     = NUM_RT * LINKS_PER_RT * FEC_W;
  localparam int DONE_BIT     = 0;
  localparam int START_BIT    = 1;
  localparam int GRP_LSB      = 8;
  localparam int GRP_W        = 8;
  localparam int ID_W         = 8;

  localparam int unsigned ADDR_CTRL   = 32'h1000;
  localparam int unsigned ADDR_VER    = 32'h1004;
  localparam int unsigned ADDR_MODE0  = 32'h1020;
  localparam int unsigned MODE_STRIDE = 4;

  typedef enum logic [FEC_W-1:0] {
    FEC_NONE     = 2'd0,
    FEC_FIRECODE = 2'd1,
    FEC_RS       = 2'd2
  } fec_e;

  typedef enum logic [ID_W-1:0] {
    RT_RESET      = 8'd0,
    RT_4X10G      = 8'd1,
    RT_4X25G      = 8'd2,
    RT_2X25G      = 8'd3,
    RT_2X25G_2X10 = 8'd4,
    RT_1X25G      = 8'd5
  } rt_mode_e;
endpackage

// File: rtl/hs_regfile.sv
module hs_regfile
  import hs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           h_wr_en,
  input  logic                           h_rd_en,
  input  logic [ADDR_W-1:0]              h_addr,
  input  logic [WORD_W-1:0]              h_wdata,
  output logic [WORD_W-1:0]              h_rdata,
  output logic                           h_rvalid,
  input  logic                           e_wr_en,
  input  logic [ADDR_W-1:0]              e_addr,
  input  logic [WORD_W-1:0]              e_wdata,
  output logic                           done_q,
  output logic                           start_q,
  output logic [FEC_BITS-1:0]            fec_q,
  output logic [WORD_W-1:0]              ver_q,
  output logic [NUM_RT-1:0][WORD_W-1:0]  mode_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(ADDR_VER);

  logic h_ctrl_we, e_ctrl_we, e_ver_we;
  logic [WORD_W-1:0] ctrl_word, rd_mux;

  assign h_ctrl_we = h_wr_en && (h_addr == A_CTRL);
  assign e_ctrl_we = e_wr_en && (e_addr == A_CTRL);
  assign e_ver_we  = e_wr_en && (e_addr == A_VER);

  logic unused_wbits;
  assign unused_wbits = ^{h_wdata[WORD_W-1:FEC_LSB+FEC_BITS],
                          h_wdata[FEC_LSB-1:START_BIT+1], h_wdata[DONE_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      fec_q   <= '0;
      ver_q   <= '0;
    end else begin
      if (h_ctrl_we) begin
        start_q <= h_wdata[START_BIT];
        fec_q   <= h_wdata[FEC_LSB +: FEC_BITS];
      end
      if (e_ctrl_we && e_wdata[DONE_BIT]) done_q <= 1'b1;
      if (e_ver_we) ver_q <= e_wdata;
    end
  end

  for (genvar r = 0; r < NUM_RT; r++) begin : g_mode
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE0 + r * MODE_STRIDE);
    always_ff @(posedge clk) begin
      if (rst) mode_q[r] <= '0;
      else if (e_wr_en && (e_addr == A_MODE)) mode_q[r] <= e_wdata;
    end

    assert_host_no_mode_wr_R4: assert property (@(posedge clk) disable iff (rst)
      (h_wr_en && h_addr == A_MODE && !(e_wr_en && e_addr == A_MODE)) |=> $stable(mode_q[r]));
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[DONE_BIT]  = done_q;
    ctrl_word[START_BIT] = start_q;
    ctrl_word[FEC_LSB +: FEC_BITS] = fec_q;
  end

  always_comb begin
    rd_mux = '0;
    if (h_addr == A_CTRL) rd_mux = ctrl_word;
    if (h_addr == A_VER)  rd_mux = ver_q;
    for (int r = 0; r < NUM_RT; r++) begin
      if (h_addr == ADDR_W'(ADDR_MODE0 + r * MODE_STRIDE)) rd_mux = mode_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata  <= '0;
      h_rvalid <= 1'b0;
    end else begin
      h_rvalid <= h_rd_en;
      if (h_rd_en) h_rdata <= rd_mux;
    end
  end

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

  assert_emb_no_req_wr_R2: assert property (@(posedge clk) disable iff (rst)
    (e_wr_en && !h_ctrl_we) |=> ($stable(start_q) && $stable(fec_q)));

  assert_host_no_ver_wr_R4: assert property (@(posedge clk) disable iff (rst)
    (h_wr_en && h_addr == A_VER && !e_ver_we) |=> $stable(ver_q));
endmodule

// File: rtl/hs_status.sv
module hs_status
  import hs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          done,
  input  logic [WORD_W-1:0]             ver,
  input  logic [NUM_RT-1:0][WORD_W-1:0] mode,
  output logic                          fw_absent,
  output logic                          cfg_ok,
  output logic                          fec_active
);
  logic [NUM_RT-1:0] grp_ok, fec_cap;
  logic [NUM_RT-1:0][WORD_W-GRP_LSB-GRP_W-1:0] unused_hi;

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    logic [ID_W-1:0] id;
    assign id         = mode[r][ID_W-1:0];
    assign grp_ok[r]  = (mode[r][GRP_LSB +: GRP_W] == '0);
    assign fec_cap[r] = !((id == RT_RESET) || (id == RT_4X10G));
    assign unused_hi[r] = mode[r][WORD_W-1:GRP_LSB+GRP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_absent  <= 1'b1;
      cfg_ok     <= 1'b0;
      fec_active <= 1'b0;
    end else begin
      fw_absent  <= (ver == '0);
      cfg_ok     <= done && (&grp_ok);
      fec_active <= |fec_cap;
    end
  end

  assert_cfg_needs_done_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |-> $past(done));
endmodule

// File: rtl/hs_spi_own.sv
module hs_spi_own #(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              e_sclk,
  input  logic              e_mosi,
  input  logic [NUM_CS-1:0] e_cs_n,
  output logic              e_miso,
  input  logic              h_sclk,
  input  logic              h_mosi,
  input  logic [NUM_CS-1:0] h_cs_n,
  output logic              h_miso,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n,
  input  logic              spi_miso,
  output logic              owner_host
);
  logic e_idle;
  assign e_idle = &e_cs_n;

  always_ff @(posedge clk) begin
    if (rst) owner_host <= 1'b0;
    else if (done && e_idle) owner_host <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      spi_cs_n <= '1;
    end else if (owner_host) begin
      spi_sclk <= h_sclk;
      spi_mosi <= h_mosi;
      spi_cs_n <= h_cs_n;
    end else begin
      spi_sclk <= e_sclk;
      spi_mosi <= e_mosi;
      spi_cs_n <= e_cs_n;
    end
  end

  assign e_miso = spi_miso && !owner_host;
  assign h_miso = spi_miso && owner_host;

  assert_owner_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    owner_host |=> owner_host);

  assert_grant_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(owner_host) |-> ($past(done) && $past(e_idle)));

  assert_handover_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(owner_host) |-> (&spi_cs_n));
endmodule

// File: rtl/init_handshake_arbiter.sv
module init_handshake_arbiter
  import hs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              emb_wr_en,
  input  logic [ADDR_W-1:0] emb_addr,
  input  logic [31:0]       emb_wdata,
  output logic              emb_start,
  output logic [15:0]       emb_fec_req,
  input  logic              emb_sclk,
  input  logic              emb_mosi,
  input  logic [NUM_CS-1:0] emb_cs_n,
  output logic              emb_miso,
  input  logic              host_sclk,
  input  logic              host_mosi,
  input  logic [NUM_CS-1:0] host_cs_n,
  output logic              host_miso,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs_n,
  input  logic              spi_miso,
  output logic              host_owns,
  output logic              fw_absent,
  output logic              cfg_ok,
  output logic              fec_active
);
  logic                          done_q;
  logic [WORD_W-1:0]             ver_q;
  logic [NUM_RT-1:0][WORD_W-1:0] mode_q;

  hs_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .h_wr_en  (host_wr_en),
    .h_rd_en  (host_rd_en),
    .h_addr   (host_addr),
    .h_wdata  (host_wdata),
    .h_rdata  (host_rdata),
    .h_rvalid (host_rvalid),
    .e_wr_en  (emb_wr_en),
    .e_addr   (emb_addr),
    .e_wdata  (emb_wdata),
    .done_q   (done_q),
    .start_q  (emb_start),
    .fec_q    (emb_fec_req),
    .ver_q    (ver_q),
    .mode_q   (mode_q)
  );

  hs_status u_status (
    .clk        (clk),
    .rst        (rst),
    .done       (done_q),
    .ver        (ver_q),
    .mode       (mode_q),
    .fw_absent  (fw_absent),
    .cfg_ok     (cfg_ok),
    .fec_active (fec_active)
  );

  hs_spi_own #(.NUM_CS(NUM_CS)) u_own (
    .clk        (clk),
    .rst        (rst),
    .done       (done_q),
    .e_sclk     (emb_sclk),
    .e_mosi     (emb_mosi),
    .e_cs_n     (emb_cs_n),
    .e_miso     (emb_miso),
    .h_sclk     (host_sclk),
    .h_mosi     (host_mosi),
    .h_cs_n     (host_cs_n),
    .h_miso     (host_miso),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .owner_host (host_owns)
  );
endmodule

// File: tb/tb_init_handshake_arbiter.sv
module tb_init_handshake_arbiter;
  localparam int AW = 13;
  localparam int NCS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 0, host_rd_en = 0, emb_wr_en = 0;
  logic [AW-1:0] host_addr = '0, emb_addr = '0;
  logic [31:0] host_wdata = '0, emb_wdata = '0, host_rdata;
  logic host_rvalid, emb_start;
  logic [15:0] emb_fec_req;
  logic emb_sclk = 0, emb_mosi = 0, host_sclk = 0, host_mosi = 0, spi_miso = 0;
  logic [NCS-1:0] emb_cs_n = '1, host_cs_n = '1, spi_cs_n;
  logic emb_miso, host_miso, spi_sclk, spi_mosi, host_owns, fw_absent, cfg_ok, fec_active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  init_handshake_arbiter #(.ADDR_W(AW), .NUM_CS(NCS)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic ewr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    emb_wr_en = 1; emb_addr = AW'(a); emb_wdata = d;
    @(negedge clk);
    emb_wr_en = 0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1; host_addr = AW'(a);
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] pins();
    return {spi_sclk, spi_mosi, spi_cs_n};
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    wait_n(3);
    rst = 0;
    wait_n(1);

    // R1 reset state
    hrd(16'h1000, rd); chk("R1 ctrl", rd, 0);
    hrd(16'h1004, rd); chk("R1 ver", rd, 0);
    hrd(16'h1020, rd); chk("R1 modeA", rd, 0);
    chk("R1 owner", host_owns, 0);
    chk("R1 pins", pins(), 4'b0011);
    chk("R1 flags", {fw_absent, cfg_ok, fec_active}, 3'b100);

    // R2 host write mask and read layout
    hwr(16'h1000, 32'hFFFF_FFFF);
    hrd(16'h1000, rd); chk("R2 ctrl mask", rd, 32'h00FF_FF02);
    chk("R2 emb_start", emb_start, 1);
    chk("R2 emb_fec_req", emb_fec_req, 16'hFFFF);
    chk("R2 rvalid", host_rvalid, 1);
    ewr(16'h1000, 32'h00FF_FF02);
    hrd(16'h1000, rd); chk("R2 emb write ignored", rd, 32'h00FF_FF02);
    hwr(16'h1000, 32'h0);
    hrd(16'h1000, rd); chk("R2 ctrl clear", rd, 0);

    // R3 exhaustive slot x code sweep
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < 4; v++) begin
        hwr(16'h1000, (32'(v) << (8 + 2 * k)) | 32'h2);
        hrd(16'h1000, rd);
        chk($sformatf("R3 slot %0d code %0d read", k, v), rd, (32'(v) << (8 + 2 * k)) | 32'h2);
        chk($sformatf("R3 slot %0d code %0d emb", k, v), emb_fec_req, 32'(v) << (2 * k));
      end
    end
    hwr(16'h1000, {8'h00, {8{hs_pkg::FEC_RS}}, 8'h02});
    hrd(16'h1000, rd); chk("R3 all Reed-Solomon", rd, 32'h00AA_AA02);

    // R6, R10 embedded words, R4 host writes ignored
    chk("R10 absent before", fw_absent, 1);
    ewr(16'h1004, 32'h3120_0000);
    wait_n(1);
    chk("R10 present", fw_absent, 0);
    ewr(16'h1020, 32'h0000_0002);
    ewr(16'h1024, 32'h0000_0005);
    hrd(16'h1004, rd); chk("R6 ver", rd, 32'h3120_0000);
    hrd(16'h1020, rd); chk("R6 modeA", rd, 32'h0000_0002);
    hrd(16'h1024, rd); chk("R6 modeB", rd, 32'h0000_0005);
    hrd(16'h1008, rd); chk("R6 unmapped", rd, 0);
    hwr(16'h1004, 32'hDEAD_BEEF);
    hwr(16'h1020, 32'h1234_5678);
    hwr(16'h1024, 32'h0000_0000);
    hrd(16'h1004, rd); chk("R4 ver kept", rd, 32'h3120_0000);
    hrd(16'h1020, rd); chk("R4 modeA kept", rd, 32'h0000_0002);
    hrd(16'h1024, rd); chk("R4 modeB kept", rd, 32'h0000_0005);
    ewr(16'h1004, 32'h0);
    wait_n(1);
    chk("R10 absent again", fw_absent, 1);
    ewr(16'h1004, 32'h3000_0000);

    // R12 exhaustive mode ID pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        ewr(16'h1020, 32'(a));
        ewr(16'h1024, 32'(b));
        wait_n(1);
        chk($sformatf("R12 ids %0d/%0d", a, b), fec_active, (a >= 2) || (b >= 2));
      end
    end
    chk("R11 no done", cfg_ok, 0);

    // R7 embedded owns the pins
    @(negedge clk);
    emb_sclk = 1; emb_mosi = 0; emb_cs_n = 2'b10;
    host_sclk = 0; host_mosi = 1; host_cs_n = 2'b01; spi_miso = 1;
    @(negedge clk);
    chk("R7 pins follow emb", pins(), 4'b1010);
    chk("R7 miso gate", {emb_miso, host_miso}, 2'b10);
    emb_sclk = 0; emb_mosi = 1; emb_cs_n = 2'b01;
    @(negedge clk);
    chk("R7 pins follow emb 2", pins(), 4'b0101);

    // R8 done during an active transfer, with a failing status code
    ewr(16'h1020, 32'h0000_0102);
    ewr(16'h1000, 32'h1);
    wait_n(5);
    chk("R8 no grant mid-transfer", host_owns, 0);
    chk("R8 emb still drives", pins(), 4'b0101);
    hrd(16'h1000, rd); chk("R5 done visible", rd[0], 1);
    chk("R11 bad status", cfg_ok, 0);
    @(negedge clk);
    emb_cs_n = 2'b11; emb_sclk = 0; emb_mosi = 0;
    wait_n(3);
    chk("R8 grant after idle", host_owns, 1);

    // R9 host owns the pins
    host_sclk = 1; host_mosi = 1; host_cs_n = 2'b10;
    emb_sclk = 0; emb_mosi = 0; emb_cs_n = 2'b00;
    @(negedge clk);
    chk("R9 pins follow host", pins(), 4'b1110);
    chk("R9 miso gate", {emb_miso, host_miso}, 2'b01);
    host_sclk = 0; host_cs_n = 2'b01; emb_cs_n = 2'b11;
    @(negedge clk);
    chk("R9 pins follow host 2", pins(), 4'b0101);

    // R5 done sticky
    ewr(16'h1000, 32'h0);
    hwr(16'h1000, 32'h0);
    hrd(16'h1000, rd); chk("R5 done sticky", rd, 32'h1);
    wait_n(4);
    chk("R9 owner sticky", host_owns, 1);

    // R11 status recovers
    ewr(16'h1020, 32'h0000_0003);
    ewr(16'h1024, 32'h0000_0001);
    wait_n(1);
    chk("R11 ok", cfg_ok, 1);
    chk("R12 after done", fec_active, 1);
    ewr(16'h1024, 32'h0000_0201);
    wait_n(1);
    chk("R11 B fails", cfg_ok, 0);

    // R1 reset returns ownership
    @(negedge clk); rst = 1;
    wait_n(2);
    @(negedge clk); rst = 0;
    chk("R1 owner after reset", host_owns, 0);
    hrd(16'h1000, rd); chk("R1 ctrl after reset", rd, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule